// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a simple synchronous request port to an asynchronous static RAM. The RAM has active-low write and output strobes and one bidirectional data bus. A requester offers an access when `req_ready` is high. The block registers the address and any write data, then plays out the strobe sequence over a set number of clock cycles. Read data comes back with a single-cycle `rsp_valid` pulse.

For writes, the address and data are driven for a programmable setup period before the write strobe falls. The strobe stays low for a programmable pulse width. Address and data are then held for a programmable hold period after the strobe rises, and only after that is the bus driver released. For reads, the output strobe is held low with a stable address for a programmable access time, and the bus is sampled on the clock edge that ends that window.

The sequencer only opens its bus driver in write phases and only lowers the output strobe in the read phase, so the block and the RAM never drive the data pins together. Every interval is a parameter counted in clock cycles, each at least 1.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mem_we_n` and `mem_oe_n` are both 1, the block's bus driver is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `mem_we_n` and `mem_oe_n` are never both 0 in the same cycle.
- R3: The block's bus driver is never on while `mem_oe_n` is 0, and `mem_oe_n` falls only after a cycle in which the driver was off.
- R4: After a write is accepted (`req_valid`=1, `req_write`=1, `req_ready`=1 at a clock edge), `mem_addr` and the driven bus hold the request's address and data for exactly SETUP_CYC cycles with `mem_we_n`=1 before `mem_we_n` falls.
- R5: Each write holds `mem_we_n` at 0 for exactly PULSE_CYC consecutive cycles, with address and bus data unchanged.
- R6: After `mem_we_n` rises, the address and bus data stay driven for exactly HOLD_CYC cycles. The driver is then released and `req_ready` returns to 1.
- R7: After a read is accepted (`req_write`=0), `mem_oe_n` is 0 for exactly ACCESS_CYC cycles with `mem_we_n`=1 and `mem_addr` equal to the request address.
- R8: `rsp_valid` is 1 for exactly the one cycle after `mem_oe_n` rises, and `rsp_rdata` then equals the bus value at the end of the access window, which is the stored word for that address.
- R9: `req_ready` is 0 for the whole of every access, and a request presented while `req_ready` is 0 starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Block idle, request can be taken |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | AW | RAM address |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq | inout | DW | Shared RAM data bus |

## Verification
For a write accepted at edge E, `mem_we_n` is low from edge E+SETUP_CYC to edge E+SETUP_CYC+PULSE_CYC, and `req_ready` returns at edge E+SETUP_CYC+PULSE_CYC+HOLD_CYC. For a read accepted at E, `mem_oe_n` is low from E to E+ACCESS_CYC, and `rsp_valid` with its data appears in the cycle after E+ACCESS_CYC. Each scenario task applies a request at a falling clock edge. It then steps one falling edge at a time and checks the strobes, address, bus and response against those cycle numbers, using unequal parameter values so that an off-by-one in any window shows up. The RAM model in the bench puts a corrupted word on the bus until the output enable has been low for ACCESS_CYC cycles, so sampling too early returns wrong data.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RACC   = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       we_n;
        logic       oe_n;
        logic       drv;
        logic       rvalid;
    } seq_regs_s;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic we_n,
    output logic oe_n,
    output logic drive,
    output logic rsp_valid
);

    localparam int MAXC = max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, ACCESS_CYC));
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    localparam logic [CW-1:0] LD_SETUP  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_PULSE  = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD   = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LD_ACCESS = CW'(ACCESS_CYC - 1);

    seq_regs_s     cur_q, nxt_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;

    asram_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        nxt_d.st = ST_WSETUP;
                        tmr_val  = LD_SETUP;
                    end else begin
                        nxt_d.st = ST_RACC;
                        tmr_val  = LD_ACCESS;
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_done) begin
                    nxt_d.st = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_WPULSE: begin
                if (tmr_done) begin
                    nxt_d.st = ST_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            ST_WHOLD: begin
                if (tmr_done) begin
                    nxt_d.st = ST_IDLE;
                end
            end
            ST_RACC: begin
                if (tmr_done) begin
                    nxt_d.st = ST_IDLE;
                    capture  = 1'b1;
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
        nxt_d.we_n   = (nxt_d.st != ST_WPULSE);
        nxt_d.oe_n   = (nxt_d.st != ST_RACC);
        nxt_d.drv    = (nxt_d.st == ST_WSETUP) || (nxt_d.st == ST_WPULSE) ||
                       (nxt_d.st == ST_WHOLD);
        nxt_d.rvalid = capture;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st     <= ST_IDLE;
            cur_q.we_n   <= 1'b1;
            cur_q.oe_n   <= 1'b1;
            cur_q.drv    <= 1'b0;
            cur_q.rvalid <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = (cur_q.st == ST_IDLE);
    assign we_n      = cur_q.we_n;
    assign oe_n      = cur_q.oe_n;
    assign drive     = cur_q.drv;
    assign rsp_valid = cur_q.rvalid;

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic          drive,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] wdata_out,
    output logic [DW-1:0] rdata,
    inout  wire  [DW-1:0] mem_dq
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } dp_regs_t;

    dp_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (accept) begin
            nxt_d.addr  = req_addr;
            nxt_d.wdata = req_wdata;
        end
        if (capture) begin
            nxt_d.rdata = mem_dq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_dq    = drive ? cur_q.wdata : {DW{1'bz}};
    assign mem_addr  = cur_q.addr;
    assign wdata_out = cur_q.wdata;
    assign rdata     = cur_q.rdata;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    inout  wire  [DW-1:0] mem_dq
);

    logic          accept;
    logic          capture;
    logic          dq_drive;
    logic [DW-1:0] dq_out;

    asram_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .ACCESS_CYC (ACCESS_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .drive     (dq_drive),
        .rsp_valid (rsp_valid)
    );

    asram_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .drive     (dq_drive),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_addr  (mem_addr),
        .wdata_out (dq_out),
        .rdata     (rsp_rdata),
        .mem_dq    (mem_dq)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int AW         = 18,
    parameter int DW         = 16,
    parameter int SETUP_CYC  = 1,
    parameter int PULSE_CYC  = 2,
    parameter int HOLD_CYC   = 1,
    parameter int ACCESS_CYC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [AW-1:0] mem_addr,
    input logic          dq_drive,
    input logic [DW-1:0] dq_out,
    input logic          req_ready,
    input logic          rsp_valid
);

    int   su_cnt, wl_cnt, hd_cnt, ol_cnt;
    logic pulse_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            su_cnt     <= 0;
            wl_cnt     <= 0;
            hd_cnt     <= 0;
            ol_cnt     <= 0;
            pulse_seen <= 1'b0;
        end else begin
            pulse_seen <= dq_drive && (pulse_seen || !mem_we_n);
            su_cnt <= !dq_drive ? 0 : ((mem_we_n && !pulse_seen) ? su_cnt + 1 : su_cnt);
            wl_cnt <= mem_we_n ? 0 : wl_cnt + 1;
            hd_cnt <= (!dq_drive || !mem_we_n) ? 0 : (pulse_seen ? hd_cnt + 1 : 0);
            ol_cnt <= mem_oe_n ? 0 : ol_cnt + 1;
        end
    end

    // R2
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // R3
    no_drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !dq_drive);

    // R3
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(dq_drive));

    // R4
    setup_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (su_cnt == SETUP_CYC) && dq_drive);

    // R5
    write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_drive && $past(dq_drive)) |-> ($stable(mem_addr) && $stable(dq_out)));

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wl_cnt == PULSE_CYC));

    // R6
    hold_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_drive) |-> (hd_cnt == HOLD_CYC));

    // R7
    access_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (ol_cnt == ACCESS_CYC));

    // R7
    read_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    // R8
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(mem_oe_n));

    // R8
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_we_n && mem_oe_n && !dq_drive));

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .AW         (AW),
    .DW         (DW),
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .ACCESS_CYC (ACCESS_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .dq_drive  (dq_drive),
    .dq_out    (dq_out),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

    localparam int AW  = 8;
    localparam int DW  = 16;
    localparam int SU  = 2;
    localparam int PW  = 3;
    localparam int HD  = 2;
    localparam int ACC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, mem_we_n, mem_oe_n;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] bus;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    asram_ctrl #(
        .AW(AW), .DW(DW), .SETUP_CYC(SU), .PULSE_CYC(PW),
        .HOLD_CYC(HD), .ACCESS_CYC(ACC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq(bus)
    );

    // Behavioural RAM: garbage on the bus until OE has been low ACC cycles.
    logic [DW-1:0] ram     [0:(1<<AW)-1];
    logic [DW-1:0] shadow  [0:(1<<AW)-1];
    int            oe_run;
    logic          ram_on, ram_ok;

    always @(posedge clk) begin
        if (mem_oe_n) oe_run <= 0;
        else if (oe_run < 1000) oe_run <= oe_run + 1;
    end
    assign ram_on = !mem_oe_n && mem_we_n;
    assign ram_ok = ram_on && (oe_run >= ACC - 1);
    assign bus = ram_on ? (ram_ok ? ram[mem_addr] : ~ram[mem_addr]) : {DW{1'bz}};

    always @(posedge mem_we_n) begin
        if (rst_n) ram[mem_addr] <= bus;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(mem_we_n && mem_oe_n, "R1 strobes in reset", {mem_we_n, mem_oe_n}, 2'b11);
        chk(req_ready && !rsp_valid, "R1 port in reset", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_we_n && mem_oe_n && req_ready && !rsp_valid, "R1 after reset",
            {mem_we_n, mem_oe_n, req_ready, rsp_valid}, 4'b1110);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit poke);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        shadow[a] = d;
        for (int i = 0; i < SU; i++) begin
            chk(mem_we_n && mem_oe_n, "R4 strobes in setup", {mem_we_n, mem_oe_n}, 2'b11);
            chk(mem_addr == a && bus == d, "R4 addr/data in setup", {mem_addr, bus}, {a, d});
            chk(!req_ready, "R9 busy in setup", req_ready, 0);
            @(negedge clk);
        end
        for (int i = 0; i < PW; i++) begin
            chk(!mem_we_n && mem_oe_n, "R5 strobe low", {mem_we_n, mem_oe_n}, 2'b01);
            chk(mem_addr == a && bus == d, "R5 addr/data in pulse", {mem_addr, bus}, {a, d});
            if (poke && i == 0) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = a + 8'd1;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        for (int i = 0; i < HD; i++) begin
            chk(mem_we_n && mem_oe_n, "R6 strobes in hold", {mem_we_n, mem_oe_n}, 2'b11);
            chk(mem_addr == a && bus == d, "R6 addr/data in hold", {mem_addr, bus}, {a, d});
            chk(!req_ready, "R9 busy in hold", req_ready, 0);
            @(negedge clk);
        end
        chk(req_ready && mem_we_n, "R6 ready after hold", {req_ready, mem_we_n}, 2'b11);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        logic [DW-1:0] e;
        e = shadow[a];
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < ACC; i++) begin
            chk(!mem_oe_n && mem_we_n, "R7 oe low in access", {mem_oe_n, mem_we_n}, 2'b01);
            chk(mem_addr == a, "R7 read address", mem_addr, a);
            chk(!rsp_valid && !req_ready, "R9 busy in read", {rsp_valid, req_ready}, 2'b00);
            @(negedge clk);
        end
        chk(mem_oe_n, "R7 oe released", mem_oe_n, 1);
        chk(rsp_valid, "R8 rsp pulse", rsp_valid, 1);
        chk(rsp_rdata == e, "R8 read data", rsp_rdata, e);
        chk(req_ready, "R9 ready after read", req_ready, 1);
    endtask

    task automatic t_rsp_single();
        do_read(8'h21);
        @(negedge clk);
        chk(!rsp_valid, "R8 pulse ends", rsp_valid, 0);
    endtask

    task automatic t_ignored_request();
        do_write(8'h40, 16'h1357, 1'b1);
        for (int i = 0; i < 3; i++) begin
            chk(mem_oe_n && !rsp_valid && req_ready, "R9 busy request ignored",
                {mem_oe_n, rsp_valid, req_ready}, 3'b101);
            @(negedge clk);
        end
    endtask

    task automatic t_turnaround();
        // Write then read the same word with no gap; read then read again.
        do_write(8'h7e, 16'hbeef, 1'b0);
        do_read(8'h7e);
        do_read(8'h7e);
        do_write(8'h00, 16'h0001, 1'b0);
        do_write(8'hff, 16'hffff, 1'b0);
        do_read(8'hff);
        do_read(8'h00);
        chk(mem_oe_n || mem_we_n, "R2 strobes idle", {mem_we_n, mem_oe_n}, 2'b11);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin
            ram[i]    = DW'(i * 37 + 5);
            shadow[i] = DW'(i * 37 + 5);
        end
        repeat (3) @(posedge clk);
        t_reset();
        do_write(8'h12, 16'ha5c3, 1'b0);
        do_read(8'h12);
        do_read(8'h33);
        t_rsp_single();
        t_ignored_request();
        do_read(8'h41);
        t_turnaround();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired: actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule